// File: doc/BRIEF.md
# Prefix-Carry Modulo 2^n+1 Adder

This block adds two residues modulo 2^n+1 and returns the residue of their sum. Both operands and the result use plain binary coding on n+1 bits, so the value 2^n, which needs the top bit, is a legal operand and a legal result. The block is purely combinational and is meant to sit inside one channel of a residue-number datapath, where the 2^n+1 channel would otherwise be the slowest.

The design first forms X+Y-1. It does this by adding a constant all-ones word in a carry-save stage, which leaves two vectors. A parallel-prefix carry network works on those two vectors and produces only what is needed to learn the top bits of X+Y-1. From those bits it decides whether X+Y-1 has reached 2^n. That decision drives the carry-in of a single ripple-carry adder on the same two vectors, so the wrap-around is applied without a second adder and a selector. In the wrapped case the top result bit is cleared.

Top module: `pfx_modp1_adder`

## Requirements
- R1: For every operand pair with both values in 0..2^n, sum_o equals (op_a_i + op_b_i) mod (2^n+1).
- R2: For in-range operands, sum_o never exceeds 2^n.
- R3: When op_a_i + op_b_i is at most 2^n, sum_o equals the plain sum. This includes a result of exactly 2^n, which is coded with bit n set and bits n-1..0 clear.
- R4: When op_a_i + op_b_i is at least 2^n+1, sum_o equals op_a_i + op_b_i - 2^n - 1. The boundary sum 2^n+1 gives 0.
- R5: When both operands are 0, sum_o is 0. Here the intermediate X+Y-1 is negative, and it must not be taken as a wrap.
- R6: When both operands are 2^n, sum_o is 2^n - 1.
- R7: The result is the same when the two operands are swapped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_a_i | input | N+1 | First residue, binary, range 0..2^N |
| op_b_i | input | N+1 | Second residue, binary, range 0..2^N |
| sum_o | output | N+1 | Residue of op_a_i + op_b_i modulo 2^N+1 |

## Verification
Every result is combinational, so it is due in the same cycle as the operands that produce it. The bench drives new operands just after a rising edge and samples sum_o at the following falling edge, half a period later, so no check depends on the order of events at an edge. It covers every operand pair for an instance at N=4 and one at N=8. It also runs seeded random pairs biased toward the wrap boundary, swaps each random pair to test R7, and checks the output while reset is held with zero operands.

// File: rtl/pfx_modp1_pkg.sv
package pfx_modp1_pkg;

  // number of doubling stages a prefix tree needs to span w bits
  function automatic int unsigned prefix_levels(input int unsigned w);
    int unsigned l;
    l = 0;
    while ((32'd1 << l) < w) l++;
    return l;
  endfunction

endpackage

// File: rtl/pfx_modp1_csa.sv
// carry-save add of x, y and the constant all-ones word (i.e. x + y - 1)
module pfx_modp1_csa #(
  parameter int unsigned W = 10
) (
  input  logic [W-1:0] x_i,
  input  logic [W-1:0] y_i,
  output logic [W-1:0] sv_o,
  output logic [W-1:0] cv_o
);

  logic [W-1:0] or_xy;

  assign or_xy = x_i | y_i;
  assign sv_o  = ~(x_i ^ y_i);
  assign cv_o  = {or_xy[W-2:0], 1'b0};

  logic unused_top;
  assign unused_top = or_xy[W-1];

endmodule

// File: rtl/pfx_modp1_prefix.sv
// log-depth group-generate tree, no carry-in; grp_g_o[i] is carry into bit i+1
module pfx_modp1_prefix #(
  parameter int unsigned W = 10
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] grp_g_o
);

  localparam int unsigned LV = pfx_modp1_pkg::prefix_levels(W);

  logic [LV:0][W-1:0] gl;
  logic [LV:0][W-1:0] pl;

  assign gl[0] = a_i & b_i;
  assign pl[0] = a_i ^ b_i;

  for (genvar lv = 0; lv < LV; lv++) begin : g_lvl
    localparam int unsigned D = 32'd1 << lv;
    for (genvar i = 0; i < W; i++) begin : g_bit
      if (i >= D) begin : g_merge
        assign gl[lv+1][i] = gl[lv][i] | (pl[lv][i] & gl[lv][i-D]);
        assign pl[lv+1][i] = pl[lv][i] & pl[lv][i-D];
      end else begin : g_pass
        assign gl[lv+1][i] = gl[lv][i];
        assign pl[lv+1][i] = pl[lv][i];
      end
    end
  end

  assign grp_g_o = gl[LV];

  logic unused_p;
  assign unused_p = ^pl[LV];

endmodule

// File: rtl/pfx_modp1_ripple.sv
// plain ripple-carry adder, carry-out dropped
module pfx_modp1_ripple #(
  parameter int unsigned W = 9
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         cin_i,
  output logic [W-1:0] sum_o
);

  logic [W-1:0] c;

  assign c[0] = cin_i;

  for (genvar i = 0; i < W; i++) begin : g_fa
    assign sum_o[i] = a_i[i] ^ b_i[i] ^ c[i];
    if (i < W - 1) begin : g_cy
      assign c[i+1] = (a_i[i] & b_i[i]) | (c[i] & (a_i[i] ^ b_i[i]));
    end
  end

endmodule

// File: rtl/pfx_modp1_adder.sv
module pfx_modp1_adder #(
  parameter int unsigned N = 8
) (
  input  logic [N:0] op_a_i,
  input  logic [N:0] op_b_i,
  output logic [N:0] sum_o
);

  localparam int unsigned OW = N + 1;
  localparam int unsigned XW = N + 2;

  logic [XW-1:0] a_ext, b_ext;
  logic [XW-1:0] sv, cv;
  logic [XW-1:0] grp_g;
  logic          s_n, s_top;
  logic          corr;
  logic [OW-1:0] rsum;

  assign a_ext = {1'b0, op_a_i};
  assign b_ext = {1'b0, op_b_i};

  pfx_modp1_csa #(.W(XW)) csa_i (
    .x_i  (a_ext),
    .y_i  (b_ext),
    .sv_o (sv),
    .cv_o (cv)
  );

  pfx_modp1_prefix #(.W(XW)) pfx_i (
    .a_i     (sv),
    .b_i     (cv),
    .grp_g_o (grp_g)
  );

  // top two bits of x+y-1 in XW-bit two's complement
  assign s_n   = sv[N]   ^ cv[N]   ^ grp_g[N-1];
  assign s_top = sv[N+1] ^ cv[N+1] ^ grp_g[N];
  // wrap when 2^N <= x+y-1 (negative -1 has s_top set)
  assign corr  = s_n & ~s_top;

  pfx_modp1_ripple #(.W(OW)) rca_i (
    .a_i   (sv[OW-1:0]),
    .b_i   (cv[OW-1:0]),
    .cin_i (~corr),
    .sum_o (rsum)
  );

  assign sum_o = {rsum[N] & ~corr, rsum[N-1:0]};

  logic unused_g;
  assign unused_g = ^{grp_g[N+1], grp_g[N-2:0]};

endmodule

// File: rtl/pfx_modp1_adder_chk.sv
module pfx_modp1_adder_chk #(
  parameter int unsigned N = 8
) (
  input logic [N:0] op_a_i,
  input logic [N:0] op_b_i,
  input logic [N:0] sum_o,
  input logic       corr_i
);

  localparam logic [N+1:0] LIM  = (N+2)'(1) << N;
  localparam logic [N+1:0] MODV = LIM + (N+2)'(1);

  logic [N+1:0] tot, a_w, b_w, s_w;
  logic         in_rng;

  assign a_w    = {1'b0, op_a_i};
  assign b_w    = {1'b0, op_b_i};
  assign s_w    = {1'b0, sum_o};
  assign tot    = a_w + b_w;
  assign in_rng = (a_w <= LIM) && (b_w <= LIM);

  always_comb begin
    if (in_rng) begin
      a_r1_residue: assert (s_w == tot % MODV)
        else $error("R1 residue mismatch");
      a_r2_range: assert (s_w <= LIM)
        else $error("R2 result above 2^N");
      if (tot <= LIM) begin
        a_r3_no_wrap: assert (s_w == tot)
          else $error("R3 unwrapped sum altered");
      end
      a_r4_corr_flag: assert (corr_i == (tot > LIM))
        else $error("R4 wrap decision wrong");
      if (tot == '0) begin
        a_r5_zero: assert (s_w == '0)
          else $error("R5 zero operands");
      end
      if (a_w == LIM && b_w == LIM) begin
        a_r6_top: assert (s_w == LIM - (N+2)'(1))
          else $error("R6 both at 2^N");
      end
    end
  end

endmodule

bind pfx_modp1_adder pfx_modp1_adder_chk #(.N(N)) chk_i (
  .op_a_i (op_a_i),
  .op_b_i (op_b_i),
  .sum_o  (sum_o),
  .corr_i (corr)
);

// File: tb/pfx_modp1_adder_tb_top.sv
`timescale 1ns/1ps
module pfx_modp1_adder_tb_top;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  always #2 clk = ~clk;

  logic [8:0] a8 = '0, b8 = '0;
  logic [8:0] s8;
  logic [4:0] a4 = '0, b4 = '0;
  logic [4:0] s4;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  pfx_modp1_adder #(.N(8)) dut_i (.op_a_i(a8), .op_b_i(b8), .sum_o(s8));
  pfx_modp1_adder #(.N(4)) dut4_i (.op_a_i(a4), .op_b_i(b4), .sum_o(s4));

  function automatic int ref_add(input int a, input int b, input int n);
    return (a + b) % ((1 << n) + 1);
  endfunction

  task automatic check(input string req, input int act, input int exp, input int a, input int b);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s a=%0d b=%0d actual=%0d expected=%0d", req, a, b, act, exp);
    end
  endtask

  // full requirement set for one sampled result of width n
  task automatic judge(input int n, input int a, input int b, input int s);
    int lim;
    lim = 1 << n;
    check("R1", s, ref_add(a, b, n), a, b);
    check("R2", (s <= lim) ? 1 : 0, 1, a, b);
    if (a + b <= lim) check("R3", s, a + b, a, b);
    else              check("R4", s, a + b - lim - 1, a, b);
  endtask

  task automatic drive8(input int a, input int b);
    @(posedge clk);
    a8 = 9'(a);
    b8 = 9'(b);
    @(negedge clk);
  endtask

  task automatic drive4(input int a, input int b);
    @(posedge clk);
    a4 = 5'(a);
    b4 = 5'(b);
    @(negedge clk);
  endtask

  initial begin
    int r_a, r_b, first;
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    @(negedge clk);
    // reset state: zero operands give zero (R5)
    check("R5", int'(s8), 0, 0, 0);
    check("R5", int'(s4), 0, 0, 0);
    rst_ni = 1'b1;

    // directed corners at N=8
    drive8(256, 0);   check("R3", int'(s8), 256, 256, 0);
    drive8(0, 256);   check("R3", int'(s8), 256, 0, 256);
    drive8(128, 128); check("R3", int'(s8), 256, 128, 128);
    drive8(128, 129); check("R4", int'(s8), 0, 128, 129);
    drive8(256, 1);   check("R4", int'(s8), 0, 256, 1);
    drive8(256, 256); check("R6", int'(s8), 255, 256, 256);
    drive8(0, 0);     check("R5", int'(s8), 0, 0, 0);
    drive4(16, 16);   check("R6", int'(s4), 15, 16, 16);
    drive4(0, 0);     check("R5", int'(s4), 0, 0, 0);
    drive4(9, 8);     check("R4", int'(s4), 0, 9, 8);

    // exhaustive N=4
    for (int i = 0; i <= 16; i++)
      for (int j = 0; j <= 16; j++) begin
        drive4(i, j);
        judge(4, i, j, int'(s4));
      end

    // exhaustive N=8
    for (int i = 0; i <= 256; i++)
      for (int j = 0; j <= 256; j++) begin
        drive8(i, j);
        judge(8, i, j, int'(s8));
      end

    // seeded random, half biased to sums near 2^N+1, with swap (R7)
    for (int k = 0; k < 400; k++) begin
      r_a = int'($urandom_range(256));
      if (k % 2 == 0) begin
        r_b = 257 - r_a + int'($urandom_range(2)) - 1;
        if (r_b < 0) r_b = 0;
        if (r_b > 256) r_b = 256;
      end else begin
        r_b = int'($urandom_range(256));
      end
      drive8(r_a, r_b);
      judge(8, r_a, r_b, int'(s8));
      first = int'(s8);
      drive8(r_b, r_a);
      check("R7", int'(s8), first, r_b, r_a);
    end

    done = 1'b1;
    $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule